// File: doc/BRIEF.md
# I2C Target Port for a 16-bit Register Bank

This block connects a small bank of 16-bit registers to a two-wire I2C bus as a target device. It watches SCL and SDA through a short synchronizer, detects START, repeated START and STOP, and pulls SDA low through an output enable when it acknowledges or sends a zero. Each register moves over the bus as two bytes, upper byte first. A write transaction carries the target address with the write bit, a command byte that names the register, then the upper and the lower data byte.

A controller can read in two ways. In a pointed read it sends the address with the write bit and a command byte, then a repeated START and the address with the read bit, and gets back the named register. In a direct read the first address phase already carries the read bit, and the block returns the register that was written last, with no command byte needed. One slot of the bank is a write-only soft-reset register: a defined code written there returns every other register to its power-on value, and reading it gives zero.

Top module: `i2c_reg16_port`

## Requirements
- R1: After reset every stored register holds the power-on word 0x8000, the soft-reset slot (command 3) shows 0x0000 on `regs_o`, and `sda_oe_o` is low.
- R2: A write with target address 0x48 and bit 0 of the address byte at 0 is acknowledged on all four bytes (address, command, upper data, lower data); the command value 0 to 2 selects the register, and that register changes only after the lower data byte has been received.
- R3: A pointed read (write-phase address, command byte, repeated START, address with bit 0 at 1) returns the upper byte and then the lower byte of the selected register, each most significant bit first.
- R4: When the first address phase after a STOP carries bit 0 at 1, the block returns both bytes of the register written most recently, and a read does not change which register that is.
- R5: A read of the soft-reset slot (command 3), pointed or direct, returns 0x0000.
- R6: Writing 0x000A to command 3 returns registers 0 to 2 to 0x8000; writing any other value to command 3 changes nothing.
- R7: When the address byte does not equal 0x48, the block acknowledges none of the bytes that follow and leaves every register unchanged until the next START.
- R8: A STOP or a repeated START that arrives after the upper data byte and before the lower one discards the partial word: the register keeps its old value.
- R9: After the lower data byte of a read, the block releases SDA and keeps it released whether or not the controller acknowledges, so any further byte reads as 0xFF.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High to pull SDA low |
| regs_o | output | REG_COUNT*16 | Current bank contents, register 0 in the low 16 bits |

## Verification
A wrong protocol state shows at the pins within one SCL period: a misplaced bit counter moves the acknowledge slot, so the controller samples a missing ACK or a shifted data byte on the very next byte. A wrong register pointer or an early commit shows on `regs_o` in the clock cycle after the offending SCL edge, which the per-cycle comparison against the bench's register model catches at once. A stuck drive shows as SDA held low across a STOP or through the controller's acknowledge slot after the lower read byte.

// File: rtl/i2c_reg16_pkg.sv
// Shared types and widths for the I2C 16-bit register target.
// Assumes nothing beyond a single clock domain for all users.
package i2c_reg16_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock and derives SCL edges
// plus START and STOP conditions. Assumes clk is several times faster
// than SCL so that every bus level lasts more than STAGES+1 cycles.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Shift both lines through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the current and older samples.
    always_comb begin
        scl_o      = scl_chain[STAGES-1];
        sda_o      = sda_chain[STAGES-1];
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

endmodule

// File: rtl/i2c_reg16_bank.sv
// Bank of 16-bit registers with one write-only soft-reset slot.
// Writes to an index outside the bank are dropped; the soft-reset slot
// stores nothing and reads as zero.
module i2c_reg16_bank #(
    parameter int          REG_COUNT  = 4,
    parameter int          SOFT_IDX   = 3,
    parameter logic [15:0] RESET_CODE = 16'h000A,
    parameter logic [15:0] POR_WORD   = 16'h8000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [i2c_reg16_pkg::BYTE_W-1:0] wr_idx,
    input  logic [i2c_reg16_pkg::WORD_W-1:0] wr_data,
    input  logic [i2c_reg16_pkg::BYTE_W-1:0] rd_idx,
    output logic [i2c_reg16_pkg::WORD_W-1:0] rd_data,
    output logic [REG_COUNT*i2c_reg16_pkg::WORD_W-1:0] regs_o
);

    import i2c_reg16_pkg::*;

    localparam logic [BYTE_W-1:0] SOFT_SEL = BYTE_W'(SOFT_IDX);

    logic soft_hit;
    assign soft_hit = wr_en && (wr_idx == SOFT_SEL) && (wr_data == RESET_CODE);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_word
        localparam logic [BYTE_W-1:0] SLOT = BYTE_W'(g);
        if (g == SOFT_IDX) begin : g_soft
            assign regs_o[g*WORD_W +: WORD_W] = '0;
        end else begin : g_store
            logic [WORD_W-1:0] word_q;
            // Hold one register: own write, soft reset, or keep.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= POR_WORD;
                end else if (wr_en && wr_idx == SLOT) begin
                    word_q <= wr_data;
                end else if (soft_hit) begin
                    word_q <= POR_WORD;
                end
            end
            assign regs_o[g*WORD_W +: WORD_W] = word_q;
        end
    end

    // Read mux; out-of-range and soft-reset indices return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_idx == BYTE_W'(i)) begin
                rd_data = regs_o[i*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte-level I2C target protocol engine. Receives address, command and
// data bytes, drives ACK and read data, and issues one write pulse per
// complete 16-bit word. Assumes synchronized line inputs and edge strobes.
module i2c_tgt_engine #(
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    input  logic [i2c_reg16_pkg::WORD_W-1:0] rd_data,
    output logic sda_oe,
    output logic wr_en,
    output logic [i2c_reg16_pkg::BYTE_W-1:0] wr_idx,
    output logic [i2c_reg16_pkg::WORD_W-1:0] wr_data,
    output logic [i2c_reg16_pkg::BYTE_W-1:0] rd_idx
);

    import i2c_reg16_pkg::*;

    tgt_state_e        state, ack_next;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, msb_hold, cmd_q, last_wr, rd_ptr;
    logic              byte_sel, cmd_valid, m_nack;

    // Bus protocol sequencing, byte capture and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_next  <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '1;
            msb_hold  <= '0;
            cmd_q     <= '0;
            last_wr   <= '0;
            rd_ptr    <= '0;
            byte_sel  <= 1'b0;
            cmd_valid <= 1'b0;
            m_nack    <= 1'b1;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state     <= ST_IDLE;
                cmd_valid <= 1'b0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                byte_sel <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            state   <= ST_ACK;
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] != TGT_ADDR) begin
                                    state     <= ST_IGNORE;
                                    cmd_valid <= 1'b0;
                                end else if (rx_sh[0]) begin
                                    ack_next <= ST_RDATA;
                                    rd_ptr   <= cmd_valid ? cmd_q : last_wr;
                                end else begin
                                    ack_next <= ST_CMD;
                                end
                            end else if (state == ST_CMD) begin
                                cmd_q     <= rx_sh;
                                cmd_valid <= 1'b1;
                                byte_sel  <= 1'b0;
                                ack_next  <= ST_WDATA;
                            end else if (!byte_sel) begin
                                msb_hold <= rx_sh;
                                byte_sel <= 1'b1;
                                ack_next <= ST_WDATA;
                            end else begin
                                wr_en    <= 1'b1;
                                wr_data  <= {msb_hold, rx_sh};
                                last_wr  <= cmd_q;
                                byte_sel <= 1'b0;
                                ack_next <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state   <= ack_next;
                            bit_cnt <= '0;
                            if (ack_next == ST_RDATA) begin
                                tx_sh    <= rd_data[WORD_W-1:BYTE_W];
                                byte_sel <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                state <= ST_RACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (!m_nack && !byte_sel) begin
                                state    <= ST_RDATA;
                                tx_sh    <= rd_data[BYTE_W-1:0];
                                byte_sel <= 1'b1;
                                bit_cnt  <= '0;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pull SDA low for ACK slots and for zero bits of read data.
    always_comb begin
        sda_oe = (state == ST_ACK) || (state == ST_RDATA && !tx_sh[BYTE_W-1]);
        wr_idx = cmd_q;
        rd_idx = rd_ptr;
    end

endmodule

// File: rtl/i2c_reg16_port.sv
// Top of the I2C target port: line synchronizer, protocol engine and
// register bank. Assumes an external pull-up on SDA and that the pad
// pulls SDA low whenever sda_oe_o is high.
module i2c_reg16_port #(
    parameter logic [6:0]  TGT_ADDR    = 7'h48,
    parameter int          REG_COUNT   = 4,
    parameter int          SOFT_IDX    = 3,
    parameter logic [15:0] RESET_CODE  = 16'h000A,
    parameter logic [15:0] POR_WORD    = 16'h8000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    output logic [REG_COUNT*16-1:0]  regs_o
);

    import i2c_reg16_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_idx, rd_idx;
    logic [WORD_W-1:0] wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    i2c_reg16_bank #(
        .REG_COUNT  (REG_COUNT),
        .SOFT_IDX   (SOFT_IDX),
        .RESET_CODE (RESET_CODE),
        .POR_WORD   (POR_WORD)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/i2c_reg16_port_chk.sv
// Checker for the I2C target port, bound into every instance of the top.
// Observes the pin-side drive, the synchronized clock line and the
// engine-to-bank write and read paths.
module i2c_reg16_port_chk #(
    parameter int REG_COUNT = 4,
    parameter int SOFT_IDX  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_s,
    input logic                    sda_oe,
    input logic                    stop_det,
    input logic                    wr_en,
    input logic [7:0]              rd_idx,
    input logic [15:0]             rd_data,
    input logic [REG_COUNT*16-1:0] regs_o
);

    logic rst_q;

    // Remember the previous reset level to spot the first active cycle.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (rst_n && !rst_q) begin
            a_r1_released_after_reset: assert (!sda_oe)
                else $error("sda driven right after reset");
        end
    end

    a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    a_r2_bank_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> $past(wr_en));

    a_r5_soft_slot_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 8'(SOFT_IDX)) |-> (rd_data == 16'h0000));

    a_r8_stop_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind i2c_reg16_port i2c_reg16_port_chk #(
    .REG_COUNT (REG_COUNT),
    .SOFT_IDX  (SOFT_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .regs_o   (regs_o)
);

// File: tb/i2c_reg16_port_tb_top.sv
`timescale 1ns/1ps
// Bench for the I2C target port: a behavioural bus controller plus a
// register model compared against regs_o on every clock.
module i2c_reg16_port_tb_top;

    localparam int Q = 8;
    localparam logic [6:0] ADDR = 7'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sda_oe;
    logic [63:0] regs_o;
    wire         sda_line = sda_drv & ~sda_oe;

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    logic [15:0] exp_regs [4];
    int last_wr = 0;
    logic prev_oe = 1'b0, prev_scl = 1'b1;

    always #4 clk = ~clk;

    i2c_reg16_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs_o)
    );

    // Per-clock comparison of the bank and of the SDA drive timing.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int i = 0; i < 4; i++) begin
                m_chk++;
                if (regs_o[i*16 +: 16] !== exp_regs[i]) begin
                    m_fail++;
                    $display("FAIL R2/R6 reg %0d: actual %h expected %h", i, regs_o[i*16 +: 16], exp_regs[i]);
                end
            end
            m_chk++;
            if (prev_scl && scl_drv && sda_oe !== prev_oe) begin
                m_fail++;
                $display("FAIL R10 sda drive changed with scl high: actual %b expected %b", sda_oe, prev_oe);
            end
        end
        prev_oe  = sda_oe;
        prev_scl = scl_drv;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(Q);
            scl_drv = 1'b1; tick(2*Q);
            scl_drv = 1'b0; tick(Q);
        end
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        acked = !sda_line; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_drv = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_drv = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            scl_drv = 1'b0; tick(Q);
        end
        sda_drv = ack ? 1'b0 : 1'b1; tick(Q);
        scl_drv = 1'b1; tick(2*Q);
        scl_drv = 1'b0; tick(Q);
        sda_drv = 1'b1;
    endtask

    task automatic model_write(input int cmd, input logic [15:0] data);
        if (cmd == 3) begin
            if (data == 16'h000A)
                for (int i = 0; i < 3; i++) exp_regs[i] = 16'h8000;
        end else if (cmd < 3) begin
            exp_regs[cmd] = data;
        end
        last_wr = cmd;
    endtask

    // R2: full write; the register must not move before the lower byte.
    task automatic write_word(input int cmd, input logic [15:0] data, input string req);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk(a, req, "write addr ack", a, 1);
        send_byte(8'(cmd), a);      chk(a, req, "command ack", a, 1);
        send_byte(data[15:8], a);   chk(a, req, "upper byte ack", a, 1);
        cmp_en = 1'b0;
        send_byte(data[7:0], a);    chk(a, req, "lower byte ack", a, 1);
        model_write(cmd, data);
        cmp_en = 1'b1;
        bus_stop();
    endtask

    task automatic pointed_read(input int cmd, input logic [15:0] exp, input string req);
        bit a;
        logic [7:0] hi, lo;
        bus_start();
        send_byte({ADDR, 1'b0}, a); chk(a, req, "read setup addr ack", a, 1);
        send_byte(8'(cmd), a);      chk(a, req, "read setup cmd ack", a, 1);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk(a, req, "read addr ack", a, 1);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        chk({hi, lo} == exp, req, "pointed read word", {hi, lo}, exp);
        chk(sda_oe == 1'b0, "R9", "released after lower byte", sda_oe, 0);
        bus_stop();
    endtask

    task automatic direct_read(input logic [15:0] exp, input string req);
        bit a;
        logic [7:0] hi, lo;
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk(a, req, "direct addr ack", a, 1);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        chk({hi, lo} == exp, req, "direct read word", {hi, lo}, exp);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] hi, lo, extra;
        exp_regs[0] = 16'h8000; exp_regs[1] = 16'h8000;
        exp_regs[2] = 16'h8000; exp_regs[3] = 16'h0000;
        tick(6);
        rst_n = 1'b1;
        tick(2);
        chk(sda_oe == 1'b0, "R1", "sda drive after reset", sda_oe, 0);
        chk(regs_o == {16'h0000, 16'h8000, 16'h8000, 16'h8000}, "R1", "bank after reset",
            regs_o[31:0], 32'h80008000);
        cmp_en = 1'b1;
        tick(Q);

        write_word(0, 16'h1234, "R2");
        write_word(1, 16'hA5C3, "R2");
        pointed_read(0, 16'h1234, "R3");
        direct_read(16'hA5C3, "R4");
        pointed_read(3, 16'h0000, "R5");
        direct_read(16'hA5C3, "R4");

        // R7: foreign address, nothing acknowledged, bank untouched.
        bus_start();
        send_byte({7'h21, 1'b0}, a); chk(!a, "R7", "foreign addr ack", a, 0);
        send_byte(8'h00, a);         chk(!a, "R7", "foreign cmd ack", a, 0);
        send_byte(8'hFF, a);         chk(!a, "R7", "foreign data ack", a, 0);
        send_byte(8'h00, a);         chk(!a, "R7", "foreign data ack", a, 0);
        bus_stop();

        // R8: STOP after the upper byte leaves register 2 alone.
        bus_start();
        send_byte({ADDR, 1'b0}, a); send_byte(8'd2, a);
        send_byte(8'h55, a); chk(a, "R8", "upper byte ack", a, 1);
        bus_stop();
        pointed_read(2, 16'h8000, "R8");

        // R8: repeated START after the upper byte, then read register 2.
        bus_start();
        send_byte({ADDR, 1'b0}, a); send_byte(8'd2, a);
        send_byte(8'h66, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a); chk(a, "R8", "restart read ack", a, 1);
        recv_byte(1'b1, hi); recv_byte(1'b0, lo);
        chk({hi, lo} == 16'h8000, "R8", "word after aborted write", {hi, lo}, 16'h8000);
        bus_stop();

        // R9: controller acknowledges the lower byte; a third byte is all ones.
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b1, hi); recv_byte(1'b1, lo); recv_byte(1'b0, extra);
        chk({hi, lo} == 16'hA5C3, "R4", "direct read with ack", {hi, lo}, 16'hA5C3);
        chk(extra == 8'hFF, "R9", "byte past the word", extra, 8'hFF);
        bus_stop();

        // R6: a wrong code does nothing, the right code restores power-on values.
        write_word(3, 16'h0001, "R6");
        chk(regs_o[15:0] == 16'h1234, "R6", "reg0 after wrong code", regs_o[15:0], 16'h1234);
        write_word(2, 16'h4321, "R2");
        write_word(3, 16'h000A, "R6");
        chk(regs_o[47:0] == {3{16'h8000}}, "R6", "bank after reset code", regs_o[31:0], 32'h80008000);
        pointed_read(1, 16'h8000, "R6");
        direct_read(16'h0000, "R5");

        tick(4*Q);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

endmodule